// File: doc/BRIEF.md
# Pseudo-Random Cache Miss Stall Controller

This block stands in for a data cache in a pipelined core model. It does not look anything up. Each load or store that reaches the memory stage steps a small modular generator, X' = (A*X + C) mod M. The new value is compared with a fixed threshold: below the threshold the access counts as a miss, otherwise as a hit. The sequence depends only on reset and on the number of accepted accesses, so every run of a program sees the same pattern of hits and misses.

A miss loads a signed countdown with the miss delay. The idle value of that countdown is -1. While the countdown is zero or above, the freeze output holds every pipeline stage in place. The countdown drops by one at the end of each frozen cycle, so a miss freezes the pipeline for DELAY+1 cycles. A hit costs no cycles. The block counts hits, misses and total accesses. The access address is taken in but has no part in the decision.

Top module: `cache_miss_stall_ctrl`

## Requirements
- R1: While rst is high, and on the first cycle after it, the generator value is 0, the countdown is idle, stall_o, hit_o and miss_o are low, and all three counters read 0. A reset in the middle of a run restarts the sequence.
- R2: Each accepted access replaces the generator value X with (2*X + 1) mod 101, starting from 0. The first twelve values are 1, 3, 7, 15, 31, 63, 26, 53, 6, 13, 27, 55 and the next six are 10, 21, 43, 87, 74, 48.
- R3: An accepted access is a miss when its new generator value is strictly less than MISS_THRESH (default 20), and a hit otherwise. Exactly one of hit_o or miss_o goes high, for one cycle, in the cycle after the edge that accepted the access.
- R4: At the edge that accepts an access, access_count_o increases by one, and so does hit_count_o or miss_count_o, whichever matches the outcome. access_count_o always equals hit_count_o plus miss_count_o.
- R5: A miss drives stall_o high for exactly MISS_DELAY+1 consecutive cycles (4 by default), starting in the same cycle as miss_o. A hit leaves stall_o low.
- R6: An access strobe in a cycle where stall_o is high is ignored. The generator does not step, no counter changes and no flag is raised.
- R7: mem_addr_i has no effect on the outcome. The same sequence of outcomes results whatever address comes with each access.
- R8: With stall_o low, the strobe is accepted on every clock edge. Back-to-back hits complete one per cycle with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_access_i | input | 1 | A load or store is in the memory stage this cycle |
| mem_addr_i | input | ADDR_W | Access address (not used in the decision) |
| stall_o | output | 1 | Freeze all pipeline stages this cycle |
| hit_o | output | 1 | One-cycle pulse: the last accepted access was a hit |
| miss_o | output | 1 | One-cycle pulse: the last accepted access was a miss |
| hit_count_o | output | CNT_W | Number of hits |
| miss_count_o | output | CNT_W | Number of misses |
| access_count_o | output | CNT_W | Number of accepted accesses |

## Verification
The bench holds the strobe high through the whole of a freeze. A design that accepted strobes while frozen would step the generator early, and every later hit or miss would then disagree with the expected sequence. The length of each freeze is counted, which catches an off-by-one in the countdown: a freeze that ends at 0 instead of -1 lasts MISS_DELAY cycles, not MISS_DELAY+1. The generator values 15, 26 and 13 lie close to the threshold of 20, and the wrap of 63 to 26 exercises the modulus, so a wrong comparison or a missing modulo changes which accesses miss. A reset in the middle of a run must bring the sequence back to its first value, 1, which is a miss.

// File: rtl/mstall_pkg.sv
package mstall_pkg;

    // Default generator constants and miss behaviour
    localparam int unsigned GEN_MUL_DEF    = 2;
    localparam int unsigned GEN_INC_DEF    = 1;
    localparam int unsigned GEN_MOD_DEF    = 101;
    localparam int unsigned MISS_THR_DEF   = 20;
    localparam int unsigned MISS_DELAY_DEF = 3;

    // Outcome of one accepted access
    typedef struct packed {
        logic hit;
        logic miss;
    } access_outcome_t;

    // One step of the modular generator
    function automatic logic [31:0] gen_step(
        input logic [31:0] cur,
        input logic [31:0] mul,
        input logic [31:0] inc,
        input logic [31:0] modv
    );
        return (mul * cur + inc) % modv;
    endfunction

endpackage

// File: rtl/mstall_lcg.sv
module mstall_lcg
    import mstall_pkg::*;
#(
    parameter int unsigned GEN_MUL    = GEN_MUL_DEF,
    parameter int unsigned GEN_INC    = GEN_INC_DEF,
    parameter int unsigned GEN_MOD    = GEN_MOD_DEF,
    parameter int unsigned MISS_THR   = MISS_THR_DEF,
    parameter int unsigned STATE_W    = $clog2(GEN_MOD)
) (
    input  logic clk,
    input  logic rst,
    input  logic step_i,
    output logic miss_now_o
);
    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_next;

    always_comb begin
        state_next = STATE_W'(gen_step(32'(state_q), 32'(GEN_MUL),
                                       32'(GEN_INC), 32'(GEN_MOD)));
        miss_now_o = (32'(state_next) < 32'(MISS_THR));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (step_i) begin
            state_q <= state_next;
        end
    end

    // R2
    state_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        32'(state_q) < 32'(GEN_MOD));

    // R6
    state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(state_q));

endmodule

// File: rtl/mstall_countdown.sv
module mstall_countdown #(
    parameter int unsigned MISS_DELAY = 3,
    localparam int unsigned SW = $clog2(MISS_DELAY + 1) + 1
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic freeze_o
);
    logic signed [SW-1:0] status_q;

    // Non-negative status means a miss delay is still running
    assign freeze_o = !status_q[SW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '1;
        end else if (load_i) begin
            status_q <= SW'(MISS_DELAY);
        end else if (freeze_o) begin
            status_q <= status_q - SW'(1);
        end
    end

    // R5
    countdown_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (status_q == SW'(MISS_DELAY)));

    // R5
    countdown_step_chk: assert property (@(posedge clk) disable iff (rst)
        (freeze_o && !load_i) |=> (status_q == $past(status_q) - SW'(1)));

    // R5
    countdown_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (!freeze_o && !load_i) |=> (status_q == '1));

endmodule

// File: rtl/mstall_counters.sv
module mstall_counters
    import mstall_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  access_outcome_t   evt_i,
    output logic              hit_o,
    output logic              miss_o,
    output logic [CNT_W-1:0]  hit_cnt_o,
    output logic [CNT_W-1:0]  miss_cnt_o,
    output logic [CNT_W-1:0]  total_cnt_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_o       <= 1'b0;
            miss_o      <= 1'b0;
            hit_cnt_o   <= '0;
            miss_cnt_o  <= '0;
            total_cnt_o <= '0;
        end else begin
            hit_o  <= evt_i.hit;
            miss_o <= evt_i.miss;
            if (evt_i.hit)  hit_cnt_o  <= hit_cnt_o + CNT_W'(1);
            if (evt_i.miss) miss_cnt_o <= miss_cnt_o + CNT_W'(1);
            if (evt_i.hit || evt_i.miss) total_cnt_o <= total_cnt_o + CNT_W'(1);
        end
    end

    // R3
    flag_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(hit_o && miss_o));

    // R4
    count_sum_chk: assert property (@(posedge clk) disable iff (rst)
        total_cnt_o == hit_cnt_o + miss_cnt_o);

endmodule

// File: rtl/cache_miss_stall_ctrl.sv
module cache_miss_stall_ctrl
    import mstall_pkg::*;
#(
    parameter int unsigned GEN_MUL    = GEN_MUL_DEF,
    parameter int unsigned GEN_INC    = GEN_INC_DEF,
    parameter int unsigned GEN_MOD    = GEN_MOD_DEF,
    parameter int unsigned MISS_THR   = MISS_THR_DEF,
    parameter int unsigned MISS_DELAY = MISS_DELAY_DEF,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_access_i,
    input  logic [ADDR_W-1:0] mem_addr_i,
    output logic              stall_o,
    output logic              hit_o,
    output logic              miss_o,
    output logic [CNT_W-1:0]  hit_count_o,
    output logic [CNT_W-1:0]  miss_count_o,
    output logic [CNT_W-1:0]  access_count_o
);
    logic            accept;
    logic            miss_now;
    access_outcome_t outcome;

    // A strobe seen while frozen is dropped
    assign accept       = mem_access_i && !stall_o;
    assign outcome.miss = accept && miss_now;
    assign outcome.hit  = accept && !miss_now;

    mstall_lcg #(
        .GEN_MUL  (GEN_MUL),
        .GEN_INC  (GEN_INC),
        .GEN_MOD  (GEN_MOD),
        .MISS_THR (MISS_THR)
    ) u_gen (
        .clk        (clk),
        .rst        (rst),
        .step_i     (accept),
        .miss_now_o (miss_now)
    );

    mstall_countdown #(
        .MISS_DELAY (MISS_DELAY)
    ) u_cd (
        .clk      (clk),
        .rst      (rst),
        .load_i   (outcome.miss),
        .freeze_o (stall_o)
    );

    mstall_counters #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (outcome),
        .hit_o       (hit_o),
        .miss_o      (miss_o),
        .hit_cnt_o   (hit_count_o),
        .miss_cnt_o  (miss_count_o),
        .total_cnt_o (access_count_o)
    );

    // R5
    miss_freezes_chk: assert property (@(posedge clk) disable iff (rst)
        miss_o |-> stall_o);

    // R6
    frozen_no_count_chk: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> $stable(access_count_o));

    // R8
    open_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_access_i && !stall_o) |=> (access_count_o == $past(access_count_o) + CNT_W'(1)));

    // R7
    addr_known_chk: assert property (@(posedge clk) disable iff (rst)
        mem_access_i |-> !$isunknown(mem_addr_i));

endmodule

// File: tb/cache_miss_stall_ctrl_bench.sv
module cache_miss_stall_ctrl_bench;

    localparam int DELAY = 3;
    localparam int CW    = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc = 1'b0;
    logic [31:0]   addr = '0;
    logic          stall, hit, miss;
    logic [CW-1:0] hcnt, mcnt, tcnt;

    int n_chk  = 0;
    int n_fail = 0;
    int e_hit  = 0;
    int e_miss = 0;

    always #4 clk = ~clk;

    cache_miss_stall_ctrl u_cache_miss_stall_ctrl (
        .clk            (clk),
        .rst            (rst),
        .mem_access_i   (acc),
        .mem_addr_i     (addr),
        .stall_o        (stall),
        .hit_o          (hit),
        .miss_o         (miss),
        .hit_count_o    (hcnt),
        .miss_count_o   (mcnt),
        .access_count_o (tcnt)
    );

    // {expected miss, address}; generator values 1,3,7,15,31,63,26,53,6,13,27,55
    localparam logic [32:0] TBL [12] = '{
        {1'b1, 32'h0000_0000}, {1'b1, 32'hFFFF_FFFC}, {1'b1, 32'h1234_5678},
        {1'b1, 32'h0000_0040}, {1'b0, 32'h0000_0040}, {1'b0, 32'hDEAD_BEE0},
        {1'b0, 32'h8000_0000}, {1'b0, 32'h0000_0004}, {1'b1, 32'hAAAA_5554},
        {1'b1, 32'h0000_0000}, {1'b0, 32'h7FFF_FFF0}, {1'b0, 32'h0BAD_F00C}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_counts(input string req);
        chk(int'(hcnt) == e_hit,  req, int'(hcnt), e_hit);
        chk(int'(mcnt) == e_miss, req, int'(mcnt), e_miss);
        chk(int'(tcnt) == e_hit + e_miss, req, int'(tcnt), e_hit + e_miss);
    endtask

    // Called at the negedge where the miss flag is visible. Counts the
    // frozen cycles; keeps the strobe at 'hold' while frozen (R6).
    task automatic wait_freeze(input logic hold, input string req);
        int cyc = 0;
        while (stall && cyc < 50) begin
            cyc++;
            acc = hold;
            @(negedge clk);
        end
        acc = 1'b0;
        chk(cyc == DELAY + 1, req, cyc, DELAY + 1);
    endtask

    task automatic one_access(input logic [31:0] a, input logic exp_miss,
                              input logic hold, input string req);
        acc  = 1'b1;
        addr = a;
        @(negedge clk);
        acc = 1'b0;
        if (exp_miss) e_miss++; else e_hit++;
        chk(miss == exp_miss, {req, " miss flag"}, int'(miss), int'(exp_miss));
        chk(hit == !exp_miss, {req, " hit flag"},  int'(hit),  int'(!exp_miss));
        chk_counts({req, " R4 counts"});
        if (exp_miss) begin
            wait_freeze(hold, "R5 freeze length");
            chk_counts("R6 counts unchanged after held strobe");
        end else begin
            chk(stall == 1'b0, "R5 no stall on hit", int'(stall), 0);
            @(negedge clk);
            chk(!hit && !miss, "R3 single-cycle flag", int'({hit, miss}), 0);
        end
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!stall && !hit && !miss, "R1 flags in reset", int'({stall, hit, miss}), 0);
        chk_counts("R1 counters in reset");
        rst = 1'b0;
        @(negedge clk);
        chk(!stall, "R1 idle after reset", int'(stall), 0);

        // R2, R3, R7: table of outcomes with unrelated addresses
        for (int i = 0; i < 12; i++) begin
            one_access(TBL[i][31:0], TBL[i][32], logic'(i % 2 == 0), "R2 R3 R7 table");
        end

        // Value 10: miss, strobe held through the freeze (R6)
        one_access(32'h0000_0100, 1'b1, 1'b1, "R6 held strobe");

        // R8: back-to-back hits, values 21,43,87,74,48
        acc = 1'b1;
        for (int k = 0; k < 5; k++) begin
            addr = 32'(k * 4);
            @(negedge clk);
            e_hit++;
            chk(hit && !stall, "R8 back-to-back hit", int'({hit, stall}), 2);
            chk_counts("R8 counts");
        end
        acc = 1'b0;
        @(negedge clk);
        chk(!hit && !miss, "R8 flags drop", int'({hit, miss}), 0);

        // R1: reset mid-run restarts the sequence
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        e_hit = 0;
        e_miss = 0;
        chk_counts("R1 counters after mid-run reset");
        one_access(32'h0000_0ABC, 1'b1, 1'b0, "R1 R2 restart first value");
        one_access(32'h0000_0ABC, 1'b1, 1'b0, "R2 restart second value");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule